// File: doc/BRIEF.md
# Staged Link Reset Sequencer

This block takes a high-speed serial converter link out of reset one stage at a time. It controls a set of active-low reset outputs for the clock PLL, the link core's configuration registers, the link core itself, and the transport-layer link and frame logic. The outputs are released in that order. Each release waits for a condition on the status inputs: PLL lock, configuration done, a reset-acknowledge handshake with the link core, and the core's out-of-reset flag. The sequence is not a fixed delay chain.

Each direction of the link has its own instance. The parameter `HAS_PLL` picks the variant. The transmit instance also owns the PLL reset. The receive instance has no PLL reset to drive and holds that output high.

A restart can come from the asynchronous hard reset pin or from a soft-reset bit written over a small register port. The same port sets a programmable wait limit. It also reports the current stage and a sticky timeout flag.

Top module: `link_rst_seq`

## Requirements
- R1: While `rst_ni` is low, every reset output is low and the stage code is 0. The outputs fall at once, without waiting for a clock edge.
- R2: After reset or restart, the stages advance in this order: 0 (all held), 1 (PLL reset released), 2 (register reset released), 3 (core reset released), 4 (waiting for out-of-reset), 5 (link and frame released). Stage 0 moves to stage 1 on the first clock edge.
- R3: The register-interface reset stays low until `pll_locked_i` is seen high in stage 1.
- R4: The core reset is released only on an edge where `cfg_done_i` and `pll_locked_i` are both high and `core_ack_i` is low.
- R5: After the core reset is released, the block waits in stage 3 for `core_ack_i` high. It then waits in stage 4 for `core_up_i` high. At that point the link and frame resets are released together, on the same edge.
- R6: If `pll_locked_i` is low in stage 2, 3, 4 or 5, the block returns to stage 0 on the next edge and every output goes low again.
- R7: Writing a 1 to bit 0 of address 0 sets a pending soft request. That bit reads back as 1 while the request is pending. The request takes effect on the first edge where `core_ack_i` is high: the block goes to stage 0 and the bit clears on that same edge. While `core_ack_i` is low, the request stays pending and the outputs do not change.
- R8: Address 2 reads the status word: bits [2:0] hold the stage code, and bit 8 holds the timeout flag.
- R9: Address 1 holds the wait limit (low 16 bits, default 1000). The timeout flag is set once a wait stage (1 to 4) has lasted more than the limit in cycles. A limit of 0 disables the check. A soft restart or a hard reset clears the flag.
- R10: With `HAS_PLL = 0`, `pll_rst_no` stays high at all times. The other outputs follow the same sequence as the transmit variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Management clock, 100 MHz |
| rst_ni | input | 1 | Hard reset, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| pll_locked_i | input | 1 | Core PLL lock status |
| cfg_done_i | input | 1 | Configuration of the core's registers finished |
| core_ack_i | input | 1 | Link core reset acknowledge |
| core_up_i | input | 1 | Link core out-of-reset flag |
| pll_rst_no | output | 1 | Core PLL reset, active low |
| csr_rst_no | output | 1 | Core register-interface reset, active low |
| core_rst_no | output | 1 | Link core reset, active low |
| link_rst_no | output | 1 | Transport link reset, active low |
| frame_rst_no | output | 1 | Transport frame reset, active low |

## Verification
The assertions assume that the status inputs are sampled synchronously to the management clock. They also assume that a fall of the core reset while lock is still held can only come from a soft restart. Because of that, they require the acknowledge to have been high on that edge. The bench changes every status input and register strobe on the falling edge, so each input is stable across the rising edge where it is sampled. It never lowers lock and requests a soft restart in the same cycle, so the two causes of a restart stay separate.

// File: rtl/link_rst_pkg.sv
package link_rst_pkg;

  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_LOCK = 3'd1,
    ST_CFG  = 3'd2,
    ST_ACK  = 3'd3,
    ST_UP   = 3'd4,
    ST_RUN  = 3'd5
  } seq_st_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_LIMIT = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;

  localparam int STAT_TMO_BIT = 8;

  function automatic logic is_wait(seq_st_e s);
    return (s == ST_LOCK) || (s == ST_CFG) || (s == ST_ACK) || (s == ST_UP);
  endfunction

endpackage

// File: rtl/link_rst_regs.sv
module link_rst_regs
  import link_rst_pkg::*;
#(
  parameter int DW      = 32,
  parameter int CNT_W   = 16,
  parameter int TMO_DEF = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             restart_i,
  input  seq_st_e          state_i,
  input  logic             tmo_i,
  output logic             soft_pend_o,
  output logic [CNT_W-1:0] limit_o,
  output logic [DW-1:0]    rdata_o
);

  logic             pend_q;
  logic [CNT_W-1:0] limit_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      limit_q <= CNT_W'(TMO_DEF);
    end else begin
      // restart consumes the request; a write on the same edge re-arms it
      if (we_i && addr_i == ADDR_CTRL && wdata_i[0]) pend_q <= 1'b1;
      else if (restart_i)                            pend_q <= 1'b0;
      if (we_i && addr_i == ADDR_LIMIT) limit_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL:  rdata_o[0] = pend_q;
      ADDR_LIMIT: rdata_o[CNT_W-1:0] = limit_q;
      ADDR_STAT: begin
        rdata_o[2:0]         = state_i;
        rdata_o[STAT_TMO_BIT] = tmo_i;
      end
      default: rdata_o = '0;
    endcase
  end

  assign soft_pend_o = pend_q;
  assign limit_o     = limit_q;

endmodule

// File: rtl/link_rst_fsm.sv
module link_rst_fsm
  import link_rst_pkg::*;
#(
  parameter bit HAS_PLL = 1'b1
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pll_locked_i,
  input  logic    cfg_done_i,
  input  logic    core_ack_i,
  input  logic    core_up_i,
  input  logic    soft_pend_i,
  output seq_st_e state_o,
  output logic    restart_o,
  output logic    pll_rst_no,
  output logic    csr_rst_no,
  output logic    core_rst_no,
  output logic    link_rst_no,
  output logic    frame_rst_no
);

  seq_st_e st_q, st_d;
  logic    lock_lost;

  assign restart_o = soft_pend_i & core_ack_i;
  assign lock_lost = !pll_locked_i && (st_q >= ST_CFG);

  always_comb begin
    st_d = st_q;
    if (restart_o || lock_lost) begin
      st_d = ST_HOLD;
    end else begin
      unique case (st_q)
        ST_HOLD: st_d = ST_LOCK;
        ST_LOCK: if (pll_locked_i) st_d = ST_CFG;
        ST_CFG:  if (cfg_done_i && pll_locked_i && !core_ack_i) st_d = ST_ACK;
        ST_ACK:  if (core_ack_i) st_d = ST_UP;
        ST_UP:   if (core_up_i) st_d = ST_RUN;
        ST_RUN:  st_d = ST_RUN;
        default: st_d = ST_HOLD;
      endcase
    end
  end

  // outputs registered from next state: async assert, sync release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_HOLD;
      csr_rst_no   <= 1'b0;
      core_rst_no  <= 1'b0;
      link_rst_no  <= 1'b0;
      frame_rst_no <= 1'b0;
    end else begin
      st_q         <= st_d;
      csr_rst_no   <= (st_d >= ST_CFG);
      core_rst_no  <= (st_d >= ST_ACK);
      link_rst_no  <= (st_d == ST_RUN);
      frame_rst_no <= (st_d == ST_RUN);
    end
  end

  generate
    if (HAS_PLL) begin : g_pll
      logic pll_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pll_q <= 1'b0;
        else         pll_q <= (st_d != ST_HOLD);
      end
      assign pll_rst_no = pll_q;
    end else begin : g_nopll
      assign pll_rst_no = 1'b1;
    end
  endgenerate

  assign state_o = st_q;

endmodule

// File: rtl/link_rst_tmo.sv
module link_rst_tmo
  import link_rst_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_st_e          state_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             clear_i,
  output logic             tmo_o
);

  seq_st_e          prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             in_wait;

  assign in_wait = is_wait(state_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= ST_HOLD;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= state_i;
      if (state_i != prev_q)             cnt_q <= '0;
      else if (in_wait && cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
      if (clear_i)                                            flag_q <= 1'b0;
      else if (in_wait && limit_i != '0 && cnt_q >= limit_i) flag_q <= 1'b1;
    end
  end

  assign tmo_o = flag_q;

endmodule

// File: rtl/link_rst_seq.sv
module link_rst_seq
  import link_rst_pkg::*;
#(
  parameter bit HAS_PLL = 1'b1,
  parameter int DW      = 32,
  parameter int CNT_W   = 16,
  parameter int TMO_DEF = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          pll_locked_i,
  input  logic          cfg_done_i,
  input  logic          core_ack_i,
  input  logic          core_up_i,
  output logic          pll_rst_no,
  output logic          csr_rst_no,
  output logic          core_rst_no,
  output logic          link_rst_no,
  output logic          frame_rst_no
);

  seq_st_e          state;
  logic             restart;
  logic             soft_pend;
  logic             tmo;
  logic [CNT_W-1:0] limit;

  link_rst_regs #(.DW(DW), .CNT_W(CNT_W), .TMO_DEF(TMO_DEF)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .restart_i  (restart),
    .state_i    (state),
    .tmo_i      (tmo),
    .soft_pend_o(soft_pend),
    .limit_o    (limit),
    .rdata_o    (reg_rdata_o)
  );

  link_rst_fsm #(.HAS_PLL(HAS_PLL)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pll_locked_i(pll_locked_i),
    .cfg_done_i  (cfg_done_i),
    .core_ack_i  (core_ack_i),
    .core_up_i   (core_up_i),
    .soft_pend_i (soft_pend),
    .state_o     (state),
    .restart_o   (restart),
    .pll_rst_no  (pll_rst_no),
    .csr_rst_no  (csr_rst_no),
    .core_rst_no (core_rst_no),
    .link_rst_no (link_rst_no),
    .frame_rst_no(frame_rst_no)
  );

  link_rst_tmo #(.CNT_W(CNT_W)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_i(state),
    .limit_i(limit),
    .clear_i(restart),
    .tmo_o  (tmo)
  );

endmodule

// File: rtl/link_rst_seq_chk.sv
module link_rst_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pll_locked_i,
  input logic cfg_done_i,
  input logic core_ack_i,
  input logic core_up_i,
  input logic csr_rst_no,
  input logic core_rst_no,
  input logic link_rst_no,
  input logic frame_rst_no
);

  assert_csr_after_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csr_rst_no) |-> $past(pll_locked_i));

  assert_core_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_no) |-> $past(cfg_done_i && pll_locked_i && !core_ack_i));

  assert_link_after_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_rst_no) |-> $past(core_up_i));

  assert_link_frame_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_rst_no == frame_rst_no);

  assert_core_implies_csr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_no |-> csr_rst_no);

  // with lock held, a core reset re-assertion can only be a soft restart
  assert_soft_needs_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(core_rst_no) && $past(pll_locked_i)) |-> $past(core_ack_i));

endmodule

bind link_rst_seq link_rst_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pll_locked_i(pll_locked_i),
  .cfg_done_i  (cfg_done_i),
  .core_ack_i  (core_ack_i),
  .core_up_i   (core_up_i),
  .csr_rst_no  (csr_rst_no),
  .core_rst_no (core_rst_no),
  .link_rst_no (link_rst_no),
  .frame_rst_no(frame_rst_no)
);

// File: tb/sim_link_rst_seq.sv
`timescale 1ns/1ps
module sim_link_rst_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_rx;
  logic        lock = 1'b0, cfg = 1'b0, ack = 1'b0, up = 1'b0;
  logic        tx_pll, tx_csr, tx_core, tx_link, tx_frame;
  logic        rx_pll, rx_csr, rx_core, rx_link, rx_frame;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  link_rst_seq #(.HAS_PLL(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pll_locked_i(lock), .cfg_done_i(cfg), .core_ack_i(ack), .core_up_i(up),
    .pll_rst_no(tx_pll), .csr_rst_no(tx_csr), .core_rst_no(tx_core),
    .link_rst_no(tx_link), .frame_rst_no(tx_frame)
  );

  link_rst_seq #(.HAS_PLL(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(1'b0), .reg_addr_i(2'd2),
    .reg_wdata_i(32'd0), .reg_rdata_o(rdata_rx),
    .pll_locked_i(lock), .cfg_done_i(cfg), .core_ack_i(ack), .core_up_i(up),
    .pll_rst_no(rx_pll), .csr_rst_no(rx_csr), .core_rst_no(rx_core),
    .link_rst_no(rx_link), .frame_rst_no(rx_frame)
  );

  function automatic logic [4:0] tx_vec();
    return {tx_pll, tx_csr, tx_core, tx_link, tx_frame};
  endfunction

  function automatic logic [4:0] rx_vec();
    return {rx_pll, rx_csr, rx_core, rx_link, rx_frame};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic set_in(input logic l, input logic c, input logic a, input logic u);
    lock = l; cfg = c; ack = a; up = u;
  endtask

  // {lock,cfg,ack,up} | expected {pll,csr,core,link,frame} | stage code
  localparam logic [11:0] VEC [12] = '{
    {4'b0000, 5'b10000, 3'd1},
    {4'b0000, 5'b10000, 3'd1},
    {4'b1000, 5'b11000, 3'd2},
    {4'b1000, 5'b11000, 3'd2},
    {4'b1110, 5'b11000, 3'd2},
    {4'b1100, 5'b11100, 3'd3},
    {4'b1100, 5'b11100, 3'd3},
    {4'b1110, 5'b11100, 3'd4},
    {4'b1111, 5'b11111, 3'd5},
    {4'b0011, 5'b00000, 3'd0},
    {4'b0000, 5'b10000, 3'd1},
    {4'b1000, 5'b11000, 3'd2}
  };

  initial begin
    logic [31:0] rd;
    // R1: reset state
    step(2);
    check("R1 outputs in reset", {27'd0, tx_vec()}, 32'h0);
    reg_rd(2'd2, rd);
    check("R8 stage in reset", rd, 32'h0);
    check("R10 rx pll in reset", {31'd0, rx_pll}, 32'h1);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R8 R10
    for (int i = 0; i < 12; i++) begin
      set_in(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8]);
      step(1);
      check($sformatf("R2 tx outputs vec %0d", i), {27'd0, tx_vec()}, {27'd0, VEC[i][7:3]});
      check($sformatf("R10 rx outputs vec %0d", i), {27'd0, rx_vec()}, {27'd0, 1'b1, VEC[i][6:3]});
      reg_rd(2'd2, rd);
      check($sformatf("R8 stage vec %0d", i), {29'd0, rd[2:0]}, {29'd0, VEC[i][2:0]});
    end

    // R7: soft request held while ack low, taken when ack rises
    set_in(1, 1, 0, 0);
    step(1);
    check("R4 core released", {27'd0, tx_vec()}, 32'b11100);
    reg_wr(2'd0, 32'h1);
    step(3);
    check("R7 held while ack low", {27'd0, tx_vec()}, 32'b11100);
    reg_rd(2'd0, rd);
    check("R7 pending bit set", rd, 32'h1);
    ack = 1'b1;
    step(1);
    check("R7 restart on ack", {27'd0, tx_vec()}, 32'b00000);
    reg_rd(2'd0, rd);
    check("R7 pending bit cleared", rd, 32'h0);

    // bring to run, then soft restart with ack high
    set_in(1, 1, 0, 0);
    step(3);
    set_in(1, 1, 1, 0);
    step(1);
    up = 1'b1;
    step(1);
    check("R5 run reached", {27'd0, tx_vec()}, 32'b11111);
    reg_wr(2'd0, 32'h1);
    check("R7 not yet restarted", {27'd0, tx_vec()}, 32'b11111);
    step(1);
    check("R7 restart from run", {27'd0, tx_vec()}, 32'b00000);

    // R9: timeout in lock-wait stage
    set_in(0, 0, 0, 0);
    reg_wr(2'd1, 32'd5);
    reg_rd(2'd1, rd);
    check("R9 limit readback", rd, 32'd5);
    reg_rd(2'd2, rd);
    check("R9 no timeout yet", rd, 32'd1);
    step(20);
    reg_rd(2'd2, rd);
    check("R9 timeout flag set", rd, 32'h101);
    ack = 1'b1;
    reg_wr(2'd0, 32'h1);
    step(1);
    reg_rd(2'd2, rd);
    check("R9 flag cleared by restart", rd, 32'h0);
    reg_wr(2'd1, 32'd0);
    step(20);
    reg_rd(2'd2, rd);
    check("R9 limit zero disables", rd, 32'd1);

    // R1: hard reset asserts outputs without a clock edge
    set_in(1, 1, 0, 0);
    step(3);
    set_in(1, 1, 1, 1);
    step(2);
    check("R5 run again", {27'd0, tx_vec()}, 32'b11111);
    #0.5 rst_n = 1'b0;
    #0.2;
    check("R1 async assert", {27'd0, tx_vec()}, 32'b00000);
    check("R1 rx async assert", {27'd0, rx_vec()}, 32'b10000);
    reg_rd(2'd2, rd);
    check("R1 stage zero", rd, 32'h0);
    step(1);
    rst_n = 1'b1;
    step(1);
    check("R2 first edge releases pll", {27'd0, tx_vec()}, 32'b10000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule